// File: doc/BRIEF.md
# Descending Hardware Stack Controller

This block keeps a stack pointer and a small byte-wide data store, and it runs the push and pop sequences for eight-byte values. A push first moves the pointer eight bytes toward lower addresses and then writes the value there. A pop reads the eight bytes at the pointer and only afterwards moves the pointer eight bytes back up. Values are laid out with the least significant byte at the lowest address. A popped slot is not cleared, so its bytes stay in place until a later push overwrites them.

Each command runs as a fixed sequence of one byte access per cycle plus one pointer-update cycle. While a sequence runs, `busy` is high and every command input is ignored. A pointer load takes effect at once when the unit is idle. Pointer arithmetic wraps modulo the store size (2^ADDR_W bytes) and raises no error. The pointer readout is 64 bits wide, with every bit above ADDR_W held at zero.

Top module: `stk_engine`

## Requirements
- R1: While `rst_n` is low and after it is released, `sp_out` is 0 and `busy` and `pop_valid` are 0.
- R2: A push accepted at an edge lowers `sp_out` by 8 (mod 2^ADDR_W) one edge later, then writes the accepted `push_data` into the eight bytes starting at the new pointer.
- R3: A pop returns, on `pop_data`, the eight bytes starting at the pointer. `pop_valid` is a one-cycle pulse that starts in the same cycle that `busy` falls, and `sp_out` rises by 8 in that same cycle.
- R4: Storage is little-endian: bits [8k+7:8k] of a value live at address pointer+k (mod 2^ADDR_W), so a pop at an unaligned pointer returns bytes from neighbouring slots in address order.
- R5: A pop does not alter memory: popping the same slot again after reloading the pointer returns the same value.
- R6: While `busy` is high, `push_req`, `pop_req`, `load_req`, `push_data` and `load_ptr` have no effect on the pointer, the stored data or the returned data.
- R7: A load while idle sets `sp_out` to `load_ptr` modulo 2^ADDR_W at the next edge, takes no busy cycles, and keeps the upper bits of `sp_out` at zero.
- R8: Pointer and byte addresses wrap modulo 2^ADDR_W: a push at pointer 0 gives pointer 2^ADDR_W-8, and an access crossing the top address continues at address 0.
- R9: When several requests are high while idle, push wins over pop and pop wins over load.
- R10: Every push and every pop holds `busy` high for exactly UNIT_BYTES+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_req | input | 1 | Start a push (sampled when idle) |
| push_data | input | 64 | Value to push, captured on acceptance |
| pop_req | input | 1 | Start a pop (sampled when idle) |
| load_req | input | 1 | Load the pointer (sampled when idle) |
| load_ptr | input | 64 | New pointer value; only the low ADDR_W bits are kept |
| busy | output | 1 | A push or pop sequence is running |
| pop_valid | output | 1 | One-cycle strobe marking `pop_data` valid |
| pop_data | output | 64 | Value read by the last pop |
| sp_out | output | 64 | Current stack pointer, zero-extended |

## Verification
A wrong pointer shows within one cycle of acceptance on `sp_out`. It also shows later as popped data assembled from the wrong addresses. A byte lane or address offset that is misplaced in the store stays hidden until a pop covers that slot, so the bench sweeps a push-then-pop round trip over every start pointer and adds unaligned pops that expose byte order. A sequencer that runs long or short shows as a wrong `busy` length, or as a `pop_valid` pulse that does not line up with the falling edge of `busy`.

// File: rtl/stk_pkg.sv
// Shared types for the stack controller: sequencer state encoding.
package stk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEC  = 3'd1,
        ST_WR   = 3'd2,
        ST_RD   = 3'd3,
        ST_INC  = 3'd4
    } stk_state_e;
endpackage

// File: rtl/stk_ctrl.sv
// Sequencer for push/pop. Push: one pointer-decrement cycle, then one write
// per byte. Pop: one read per byte, then one pointer-increment cycle.
// Assumes UNIT_BYTES is a power of two. Push has priority over pop.
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int UNIT_BYTES = 8,
    localparam int IDX_W = $clog2(UNIT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output stk_state_e       state,
    output logic [IDX_W-1:0] byte_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNIT_BYTES - 1);

    stk_state_e state_nx;

    // Next-state selection for the command sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (push_req)      state_nx = ST_DEC;
                else if (pop_req)  state_nx = ST_RD;
            end
            ST_DEC:  state_nx = ST_WR;
            ST_WR:   if (byte_idx == LAST_IDX) state_nx = ST_IDLE;
            ST_RD:   if (byte_idx == LAST_IDX) state_nx = ST_INC;
            ST_INC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and byte counter; counter runs during byte phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            byte_idx <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WR || state == ST_RD) byte_idx <= byte_idx + 1'b1;
            else                                  byte_idx <= '0;
        end
    end
endmodule

// File: rtl/stk_ptr.sv
// Stack pointer register: step down, step up, or load. Wraps modulo 2^ADDR_W.
// Assumes at most one of dec/inc/load is high per cycle.
module stk_ptr #(
    parameter int ADDR_W = 8,
    parameter int STEP   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec,
    input  logic              inc,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] sp
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    // Pointer update, wrapping by natural overflow of ADDR_W bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp <= '0;
        else if (dec)     sp <= sp - STEP_V;
        else if (inc)     sp <= sp + STEP_V;
        else if (load_en) sp <= load_val;
    end
endmodule

// File: rtl/stk_bytemem.sv
// Byte-wide data store with one synchronous write port and one
// combinational read port. Contents are not reset.
module stk_bytemem #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    logic [7:0] cells [DEPTH];

    // Byte write on the write strobe.
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    // Asynchronous read of the addressed byte.
    always_comb rdata = cells[addr];
endmodule

// File: rtl/stk_engine.sv
// Top of the descending stack controller. Owns the pointer, the byte store
// and the sequencer; captures push data on acceptance and assembles popped
// bytes little-endian. Inputs are ignored while a sequence runs.
module stk_engine
    import stk_pkg::*;
#(
    parameter int PTR_W      = 64,
    parameter int ADDR_W     = 8,
    parameter int UNIT_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_req,
    input  logic [8*UNIT_BYTES-1:0] push_data,
    input  logic                    pop_req,
    input  logic                    load_req,
    input  logic [PTR_W-1:0]        load_ptr,
    output logic                    busy,
    output logic                    pop_valid,
    output logic [8*UNIT_BYTES-1:0] pop_data,
    output logic [PTR_W-1:0]        sp_out
);
    localparam int DATA_W = 8 * UNIT_BYTES;
    localparam int IDX_W  = $clog2(UNIT_BYTES);

    stk_state_e        state;
    logic [IDX_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] sp;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        rd_byte;
    logic [DATA_W-1:0] push_q;
    logic              idle;
    logic              load_en;
    logic              unused_load_hi;

    assign idle           = (state == ST_IDLE);
    assign load_en        = idle && load_req && !push_req && !pop_req;
    assign mem_addr       = sp + ADDR_W'(byte_idx);
    assign unused_load_hi = ^load_ptr[PTR_W-1:ADDR_W];

    stk_ctrl #(.UNIT_BYTES(UNIT_BYTES)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (pop_req),
        .state    (state),
        .byte_idx (byte_idx)
    );

    stk_ptr #(.ADDR_W(ADDR_W), .STEP(UNIT_BYTES)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec      (state == ST_DEC),
        .inc      (state == ST_INC),
        .load_en  (load_en),
        .load_val (load_ptr[ADDR_W-1:0]),
        .sp       (sp)
    );

    stk_bytemem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (state == ST_WR),
        .addr  (mem_addr),
        .wdata (push_q[8*byte_idx +: 8]),
        .rdata (rd_byte)
    );

    // Capture the push value when a push is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                push_q <= '0;
        else if (idle && push_req) push_q <= push_data;
    end

    // Assemble popped bytes by lane and pulse valid after the pointer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pop_data  <= '0;
            pop_valid <= 1'b0;
        end else begin
            if (state == ST_RD) pop_data[8*byte_idx +: 8] <= rd_byte;
            pop_valid <= (state == ST_INC);
        end
    end

    assign busy   = !idle;
    assign sp_out = {{(PTR_W-ADDR_W){1'b0}}, sp};
endmodule

// File: rtl/stk_engine_chk.sv
// Port-level property checker for stk_engine, attached with bind.
module stk_engine_chk #(
    parameter int PTR_W      = 64,
    parameter int ADDR_W     = 8,
    parameter int UNIT_BYTES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_req,
    input logic             pop_req,
    input logic             load_req,
    input logic [PTR_W-1:0] load_ptr,
    input logic             busy,
    input logic             pop_valid,
    input logic [PTR_W-1:0] sp_out
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(UNIT_BYTES);

    logic [ADDR_W-1:0] sp_lo;
    logic [7:0]        run_len;

    assign sp_lo = sp_out[ADDR_W-1:0];

    // Length of the current busy run, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !pop_valid && sp_out == '0)); // R1
    AST_PUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && push_req) |=> busy); // R2
    AST_POP_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (!busy && pop_req) |=> busy); // R3
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) pop_valid |=> !pop_valid); // R3
    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n) pop_valid |-> (!busy && $past(busy))); // R3
    AST_BUSY_STEP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && sp_lo != $past(sp_lo)) |-> (sp_lo == $past(sp_lo) - STEP_V || sp_lo == $past(sp_lo) + STEP_V)); // R6
    AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_req && !push_req && !pop_req) |=> (!busy && sp_lo == $past(load_ptr[ADDR_W-1:0]))); // R7
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) sp_out[PTR_W-1:ADDR_W] == '0); // R7
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != 8'd0) |-> run_len == 8'(UNIT_BYTES + 1)); // R10
endmodule

bind stk_engine stk_engine_chk #(
    .PTR_W(PTR_W), .ADDR_W(ADDR_W), .UNIT_BYTES(UNIT_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .load_req(load_req), .load_ptr(load_ptr), .busy(busy),
    .pop_valid(pop_valid), .sp_out(sp_out)
);

// File: tb/test_stk_engine.sv
`timescale 1ns/1ps
module test_stk_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_req = 1'b0;
    logic [63:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic        load_req = 1'b0;
    logic [63:0] load_ptr = '0;
    logic        busy;
    logic        pop_valid;
    logic [63:0] pop_data;
    logic [63:0] sp_out;

    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    logic [7:0] mmem [256];
    logic [7:0] msp;

    always #2.5 clk = ~clk;

    stk_engine i_stk_engine (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .load_req(load_req), .load_ptr(load_ptr),
        .busy(busy), .pop_valid(pop_valid), .pop_data(pop_data), .sp_out(sp_out)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // Runs one command with the given request mix; push > pop > load.
    task automatic run_cmd(input bit p, input bit q, input bit l, input logic [63:0] pd,
                           input logic [63:0] lp, input bit noise);
        logic [63:0] exp_val;
        int n;
        exp_val = '0;
        for (int k = 0; k < 8; k++) exp_val[8*k +: 8] = mmem[8'(msp + 8'(k))];
        @(negedge clk);
        push_req = p; pop_req = q; load_req = l; push_data = pd; load_ptr = lp;
        @(negedge clk);
        push_req = 0; pop_req = 0; load_req = 0; push_data = ~pd; load_ptr = ~lp;
        if (!p && !q) begin
            chk(sp_out == {56'd0, lp[7:0]}, "R7 load pointer", sp_out, {56'd0, lp[7:0]});
            chk(busy == 1'b0, "R7 load not busy", 64'(busy), 64'd0);
            msp = lp[7:0];
        end else begin
            n = 0;
            while (busy && n < 20) begin
                n++;
                if (n == 2 && p)
                    chk(sp_out == {56'd0, 8'(msp - 8'd8)}, "R2 pointer lowered first", sp_out, {56'd0, 8'(msp - 8'd8)});
                if (noise && n < 9) begin
                    push_req = 1; pop_req = 1; load_req = 1;
                    push_data = 64'(n) * 64'h0101_0101_0101_0101; load_ptr = 64'(n * 37);
                end else begin
                    push_req = 0; pop_req = 0; load_req = 0;
                end
                @(negedge clk);
            end
            push_req = 0; pop_req = 0; load_req = 0;
            chk(n == 9, "R10 busy length", 64'(n), 64'd9);
            if (p) begin
                msp = msp - 8'd8;
                for (int k = 0; k < 8; k++) mmem[8'(msp + 8'(k))] = pd[8*k +: 8];
                chk(sp_out == {56'd0, msp}, "R2 pointer after push", sp_out, {56'd0, msp});
            end else begin
                msp = msp + 8'd8;
                chk(pop_valid == 1'b1, "R3 valid with busy fall", 64'(pop_valid), 64'd1);
                chk(pop_data == exp_val, "R3 pop data", pop_data, exp_val);
                chk(sp_out == {56'd0, msp}, "R3 pointer after pop", sp_out, {56'd0, msp});
                @(negedge clk);
                chk(pop_valid == 1'b0, "R3 valid single cycle", 64'(pop_valid), 64'd0);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mmem[i] = 8'h00;
        msp = 8'h00;
        repeat (3) @(negedge clk);
        chk(sp_out == 64'd0 && !busy && !pop_valid, "R1 state in reset", sp_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp_out == 64'd0 && !busy && !pop_valid, "R1 state after reset", sp_out, 64'd0);

        // R8 R2 R3: push/pop round trip from every start pointer.
        for (int s = 0; s < 256; s++) begin
            run_cmd(0, 0, 1, 64'd0, 64'(s), 0);
            run_cmd(1, 0, 0, {8'(s), 8'(s ^ 8'hA5), 48'h1234_5678_9ABC + 48'(s * 977)}, 64'd0, 0);
            run_cmd(0, 1, 0, 64'd0, 64'd0, 0);
        end

        // R8: push at pointer 0 wraps to 0xF8.
        run_cmd(0, 0, 1, 64'd0, 64'd0, 0);
        run_cmd(1, 0, 0, 64'hCAFE_F00D_DEAD_BEEF, 64'd0, 0);
        chk(sp_out == 64'hF8, "R8 wrap on push", sp_out, 64'hF8);
        // R8: pop crossing the top address continues at 0.
        run_cmd(0, 0, 1, 64'd0, 64'hFC, 0);
        run_cmd(0, 1, 0, 64'd0, 64'd0, 0);
        chk(sp_out == 64'h04, "R8 wrap on pop", sp_out, 64'h04);

        // Scaled trace: start 0x80, push 0x123, push 0x22, pop.
        run_cmd(0, 0, 1, 64'd0, 64'h80, 0);
        run_cmd(1, 0, 0, 64'h123, 64'd0, 0);
        chk(sp_out == 64'h78, "R2 first push pointer", sp_out, 64'h78);
        run_cmd(1, 0, 0, 64'h22, 64'd0, 0);
        run_cmd(0, 1, 0, 64'd0, 64'd0, 0);
        chk(pop_data == 64'h22, "R3 trace pop value", pop_data, 64'h22);
        // R5: reload and pop the same slot again.
        run_cmd(0, 0, 1, 64'd0, 64'h70, 0);
        run_cmd(0, 1, 0, 64'd0, 64'd0, 0);
        chk(pop_data == 64'h22, "R5 data kept after pop", pop_data, 64'h22);

        // R4: unaligned pop across two slots.
        run_cmd(0, 0, 1, 64'd0, 64'h50, 0);
        run_cmd(1, 0, 0, 64'h1111_1111_1111_1111, 64'd0, 0);
        run_cmd(1, 0, 0, 64'h8877_6655_4433_2211, 64'd0, 0);
        run_cmd(0, 0, 1, 64'd0, 64'h41, 0);
        run_cmd(0, 1, 0, 64'd0, 64'd0, 0);
        chk(pop_data == 64'h1188_7766_5544_3322, "R4 little-endian lanes", pop_data, 64'h1188_7766_5544_3322);

        // R6: requests held high during busy are ignored.
        run_cmd(0, 0, 1, 64'd0, 64'hA0, 0);
        run_cmd(1, 0, 0, 64'h0F0E_0D0C_0B0A_0908, 64'd0, 1);
        chk(sp_out == 64'h98, "R6 pointer untouched during push", sp_out, 64'h98);
        run_cmd(0, 1, 0, 64'd0, 64'd0, 1);
        chk(pop_data == 64'h0F0E_0D0C_0B0A_0908, "R6 data untouched", pop_data, 64'h0F0E_0D0C_0B0A_0908);

        // R7: upper load bits dropped.
        run_cmd(0, 0, 1, 64'd0, 64'hFFFF_FFFF_FFFF_FF37, 0);
        chk(sp_out == 64'h37, "R7 upper bits zero", sp_out, 64'h37);

        // R9: priority among simultaneous requests.
        run_cmd(0, 0, 1, 64'd0, 64'hC0, 0);
        run_cmd(1, 1, 1, 64'h5555_AAAA_5555_AAAA, 64'h10, 0);
        chk(sp_out == 64'hB8, "R9 push beats pop and load", sp_out, 64'hB8);
        run_cmd(0, 1, 1, 64'd0, 64'h10, 0);
        chk(sp_out == 64'hC0, "R9 pop beats load", sp_out, 64'hC0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule